// File: doc/BRIEF.md
# Addressable Tapped Delay Line

This block delays a single-bit serial stream by a run-time selectable number of clock cycles. It is built from a chain of fixed-length segments. Each segment is a 32-stage shift register with a combinational read tap. The last stage of each segment feeds the first stage of the next one. With four segments the line offers any delay from 1 to 128 enabled clock cycles. Typical uses are delay matching between pipelines and latency compensation.

A 7-bit read address picks one stored bit. Its upper 2 bits select the segment and its lower 5 bits select the stage inside that segment. The selected bit appears on the tap output. The oldest stage of the whole chain is always available on a separate cascade output, so a further line can be chained behind this one. A build parameter inserts a flip-flop after the tap for a registered read. The stored bits start at zero, and there is no reset input. The design has no state machine: the only state is the shift chain and the optional read flop.

Top module: `tapped_delay_line`

## Requirements
- R1: Before any stored bit has been written, tap_q and cascade_q are both 0.
- R2: With the combinational read, address k (0 to 127) returns the din value sampled on the (k+1)-th most recent clock edge at which ce was 1. Address 0 returns the newest bit.
- R3: At a clock edge where ce is 0, no stored bit changes, so cascade_q keeps its value. With the combinational read, tap_q also keeps its value as long as addr is held steady.
- R4: With the combinational read, a change of addr is visible on tap_q in the same cycle, without a clock edge.
- R5: cascade_q carries the din value sampled 128 enabled edges earlier, whatever the value of addr.
- R6: addr[6:5] selects the segment and addr[4:0] selects the stage within it. Stage 31 of one segment feeds stage 0 of the next, so address 32 reads the bit that address 31 held before the last enabled edge.
- R7: A delay of N cycles is obtained with addr = N-1. For example, with addr = 12, a single 1 pulse on din appears on tap_q after exactly 13 enabled edges, for one enabled edge only.
- R8: With REG_OUT = 1, tap_q at each clock edge loads the value that the combinational read would show just before that edge. The flop updates on every edge, whatever the value of ce.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the line shifts on its rising edge |
| ce | input | 1 | Shift enable; when low, all stored bits hold |
| din | input | 1 | Serial data input |
| addr | input | 7 | Read tap select: {segment, stage} |
| tap_q | output | 1 | Selected stored bit, combinational or registered |
| cascade_q | output | 1 | Oldest stage of the chain, for chaining |

## Verification
A corrupted stage, or a broken link between segments, shows at tap_q within the same cycle once the address points at it. The same fault reaches cascade_q after at most 128 enabled edges. A clock enable that leaks through makes the tap output move during hold periods at the next edge. A wrong address split returns a bit from the wrong segment, that is, a delay off by a multiple of 32. Sweeping every address during a hold period and comparing each read against a model of the input history exposes both kinds of fault at once.

// File: rtl/dly_pkg.sv
package dly_pkg;
    localparam int DEF_SEG_DEPTH = 32;
    localparam int DEF_SEG_COUNT = 4;

    function automatic int addr_bits(input int depth, input int count);
        return $clog2(depth * count);
    endfunction
endpackage

// File: rtl/dly_segment.sv
module dly_segment #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          ce,
    input  logic          sin,
    input  logic [AW-1:0] tap_addr,
    output logic          tap_o,
    output logic          casc_o
);
    // Bit 0 holds the newest sample; stored contents start at zero.
    logic [DEPTH-1:0] chain = '0;

    always_ff @(posedge clk) begin
        if (ce) begin
            chain <= {chain[DEPTH-2:0], sin};
        end
    end

    assign tap_o  = chain[tap_addr];
    assign casc_o = chain[DEPTH-1];
endmodule

// File: rtl/dly_tap_select.sv
module dly_tap_select #(
    parameter int COUNT = 4,
    localparam int SW   = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic [SW-1:0]    sel,
    input  logic [COUNT-1:0] taps,
    output logic             pick
);
    assign pick = taps[sel];
endmodule

// File: rtl/dly_read_stage.sv
module dly_read_stage #(
    parameter bit REGISTERED = 1'b0
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    if (REGISTERED) begin : g_flop
        logic q_r = 1'b0;
        always_ff @(posedge clk) begin
            q_r <= d;
        end
        assign q = q_r;
    end else begin : g_wire
        assign q = d;
    end
endmodule

// File: rtl/tapped_delay_line.sv
module tapped_delay_line
    import dly_pkg::*;
#(
    parameter int SEG_DEPTH = DEF_SEG_DEPTH,
    parameter int SEG_COUNT = DEF_SEG_COUNT,
    parameter bit REG_OUT   = 1'b0,
    localparam int LAW      = $clog2(SEG_DEPTH),
    localparam int TAW      = addr_bits(SEG_DEPTH, SEG_COUNT)
) (
    input  logic           clk,
    input  logic           ce,
    input  logic           din,
    input  logic [TAW-1:0] addr,
    output logic           tap_q,
    output logic           cascade_q
);
    logic [SEG_COUNT-1:0] seg_in;
    logic [SEG_COUNT-1:0] seg_casc;
    logic [SEG_COUNT-1:0] seg_tap;
    logic                 tap_comb;

    // Each segment takes the oldest bit of its predecessor.
    assign seg_in = {seg_casc[SEG_COUNT-2:0], din};

    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
        dly_segment #(.DEPTH(SEG_DEPTH)) u_seg (
            .clk      (clk),
            .ce       (ce),
            .sin      (seg_in[s]),
            .tap_addr (addr[LAW-1:0]),
            .tap_o    (seg_tap[s]),
            .casc_o   (seg_casc[s])
        );
    end

    dly_tap_select #(.COUNT(SEG_COUNT)) u_sel (
        .sel  (addr[TAW-1:LAW]),
        .taps (seg_tap),
        .pick (tap_comb)
    );

    dly_read_stage #(.REGISTERED(REG_OUT)) u_rd (
        .clk (clk),
        .d   (tap_comb),
        .q   (tap_q)
    );

    assign cascade_q = seg_casc[SEG_COUNT-1];
endmodule

// File: rtl/tapped_delay_line_chk.sv
module tapped_delay_line_chk #(
    parameter int SEG_DEPTH = 32,
    parameter int SEG_COUNT = 4,
    parameter bit REG_OUT   = 1'b0,
    localparam int TOTAL    = SEG_DEPTH * SEG_COUNT,
    localparam int TAW      = $clog2(TOTAL)
) (
    input logic           clk,
    input logic           ce,
    input logic           din,
    input logic [TAW-1:0] addr,
    input logic           tap_q,
    input logic           cascade_q
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    AST_CASC_HOLD: assert property (@(posedge clk) disable iff (!armed)
        !ce |=> $stable(cascade_q)); // R3

    if (!REG_OUT) begin : g_comb
        AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!armed)
            !ce |=> ($stable(addr) -> $stable(tap_q))); // R3
        AST_NEWEST_TAP: assert property (@(posedge clk) disable iff (!armed)
            ce |=> ((addr == '0) -> (tap_q == $past(din)))); // R2
        AST_CASC_FROM_TAP: assert property (@(posedge clk) disable iff (!armed)
            (ce && addr == TAW'(TOTAL-2)) |=> (cascade_q == $past(tap_q))); // R5
        AST_SEG_LINK: assert property (@(posedge clk) disable iff (!armed)
            (ce && addr == TAW'(SEG_DEPTH-1)) |=>
            ((addr == TAW'(SEG_DEPTH)) -> (tap_q == $past(tap_q)))); // R6
    end else begin : g_reg
        AST_REG_NEWEST: assert property (@(posedge clk) disable iff (!armed)
            ($past(ce) && addr == '0) |=> (tap_q == $past(din, 2))); // R8
    end
endmodule

bind tapped_delay_line tapped_delay_line_chk #(
    .SEG_DEPTH (SEG_DEPTH),
    .SEG_COUNT (SEG_COUNT),
    .REG_OUT   (REG_OUT)
) u_chk (
    .clk       (clk),
    .ce        (ce),
    .din       (din),
    .addr      (addr),
    .tap_q     (tap_q),
    .cascade_q (cascade_q)
);

// File: tb/test_tapped_delay_line.sv
`timescale 1ns/1ps
module test_tapped_delay_line;
    localparam real HALF = 2.5;
    localparam int  NROW = 12;
    // [15:8] cycles, [7] ce, [6:0] base address
    localparam logic [15:0] PLAN [NROW] = '{
        {8'd40, 1'b1, 7'd0},   {8'd40, 1'b1, 7'd31},  {8'd30, 1'b1, 7'd32},
        {8'd20, 1'b0, 7'd5},   {8'd30, 1'b1, 7'd64},  {8'd30, 1'b1, 7'd127},
        {8'd10, 1'b0, 7'd100}, {8'd20, 1'b1, 7'd95},  {8'd20, 1'b1, 7'd63},
        {8'd15, 1'b1, 7'd96},  {8'd10, 1'b0, 7'd1},   {8'd20, 1'b1, 7'd12}
    };

    logic clk = 1'b0;
    logic ce = 1'b0;
    logic din = 1'b0;
    logic [6:0] addr = '0;
    logic tap_c, casc_c, tap_r, casc_r;
    logic [159:0] hist = '0;
    logic [15:0] lfsr = 16'hACE1;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(HALF) clk = ~clk;

    tapped_delay_line #(.REG_OUT(1'b0)) i_tapped_delay_line (
        .clk(clk), .ce(ce), .din(din), .addr(addr),
        .tap_q(tap_c), .cascade_q(casc_c));

    tapped_delay_line #(.REG_OUT(1'b1)) i_tapped_delay_line_reg (
        .clk(clk), .ce(ce), .din(din), .addr(addr),
        .tap_q(tap_r), .cascade_q(casc_r));

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // One cycle: drive, check combinational read, clock, check registered read.
    task automatic step(input logic ce_v, input logic din_v, input logic [6:0] a_v);
        logic pend;
        @(negedge clk);
        ce = ce_v; din = din_v; addr = a_v;
        #1;
        chk("R2/R6 tap", tap_c, hist[addr]);
        chk("R5 cascade", casc_c, hist[127]);
        pend = hist[addr];
        @(posedge clk);
        if (ce) hist = {hist[158:0], din};
        #1;
        chk("R8 registered tap", tap_r, pend);
    endtask

    initial begin
        #1;
        chk("R1 tap", tap_c, 1'b0);
        chk("R1 cascade", casc_c, 1'b0);
        chk("R1 reg tap", tap_r, 1'b0);

        for (int r = 0; r < NROW; r++) begin
            for (int i = 0; i < int'(PLAN[r][15:8]); i++) begin
                if (PLAN[r][7]) step(1'b1, next_bit(), PLAN[r][6:0]);
                else            step(1'b0, next_bit(), PLAN[r][6:0] + 7'(i));
            end
        end

        // R3: hold with ce low, then R4: sweep all addresses with no clock edge.
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 7'd77);
        for (int a = 0; a < 128; a++) begin
            addr = 7'(a);
            #0.01;
            chk("R4 comb sweep", tap_c, hist[a]);
        end
        chk("R3 cascade hold", casc_c, hist[127]);

        // R7: 13-cycle delay through address 12.
        for (int i = 0; i < 130; i++) step(1'b1, 1'b0, 7'd12);
        step(1'b1, 1'b1, 7'd12);
        for (int k = 2; k <= 16; k++) begin
            step(1'b1, 1'b0, 7'd12);
            chk("R7 pulse at 13", tap_c, (k == 13) ? 1'b1 : 1'b0);
        end

        // R5: pulse reaches cascade after 128 enabled edges, address irrelevant.
        for (int k = 17; k <= 129; k++) begin
            step(1'b1, 1'b0, 7'(k));
            if (k >= 127) chk("R5 cascade pulse", casc_c, (k == 128) ? 1'b1 : 1'b0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 2 * HALF);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule